// File: doc/BRIEF.md
# Sample Rate Ratio Servo Loop

This block tracks the rate ratio between two asynchronous sample strobes, an input-frame strobe and an output-frame strobe. Both strobes are sampled in one fast system clock domain. Each rising edge of the input strobe advances a write count. Each rising edge of the output strobe closes one turn of a second-order control loop. A phase detector compares the write count with the integer part of a fractional read position. A proportional-plus-integral filter turns that error into a position increment. The increment is added to the read position.

After every output event the block presents the new read position as two fields. The integer field is the start address for reading the input sample FIFO. The fractional field is the start offset into the polyphase coefficient table. The FIFO and the convolver that use these values are outside this block.

A settling-select input chooses the loop filter gains, either slow and quiet or fast and tight. It may be changed at any time and needs no reset.

Top module: `asrc_ratio_servo`

## Requirements
- R1: While reset is held and after it is released, until the first output event: `rd_start` = 2^INT_W − 2^(INT_W−1) (32 with defaults), `coef_ofs` = 0 and `out_valid` = 0. The read position therefore starts half a FIFO behind a write count of zero.
- R2: Each low-to-high transition of `in_lr`, seen on consecutive clock edges, increments the internal write count by exactly one, modulo 2^INT_W. A strobe held high counts only once.
- R3: If `out_lr` is sampled low at edge k−1 and high at edge k, then `out_valid` is high for exactly the one cycle between edges k+1 and k+2. At all other times it is low.
- R4: `rd_start` and `coef_ofs` change only on the edge at which `out_valid` rises. Between output events they hold their values.
- R5: At each output event the phase error e is (write count − current `rd_start` − 2^(INT_W−1)), taken modulo 2^INT_W as a signed INT_W-bit value. An input edge detected in the same cycle is not yet included in the count.
- R6: At each output event the integrator I (reset value 1.0, that is 2^FRAC_W) becomes I + e·2^(FRAC_W−KI). The position P becomes P + I_new + e·2^(FRAC_W−KP), modulo 2^(INT_W+FRAC_W). `rd_start` is P[INT_W+FRAC_W−1:FRAC_W] and `coef_ofs` is P[FRAC_W−1:0].
- R7: `slow_sel`=1 selects KP=KP_SLOW and KI=KI_SLOW. `slow_sel`=0 selects both shifts smaller by FAST_DELTA. The value registered one edge before an output event applies to that event, and the setting may change mid-run without reset.
- R8: If both strobes have the same period and rise on the same cycle from reset, every output event advances `rd_start` by exactly 1 and leaves `coef_ofs` at 0.
- R9: After a step in the input rate, the largest |e| seen with fast settling is smaller than with slow settling, and both stay below 2^(INT_W−1). The read and write positions therefore never cross.
- R10: The integer position wraps from 2^INT_W−1 to 0 without disturbing the loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast common clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_lr | input | 1 | Input frame strobe, one rising edge per input sample |
| out_lr | input | 1 | Output frame strobe, one rising edge per output sample |
| slow_sel | input | 1 | 1 selects slow settling, 0 selects fast settling |
| rd_start | output | INT_W | Integer read position, FIFO start address |
| coef_ofs | output | FRAC_W | Fractional read position, coefficient start offset |
| out_valid | output | 1 | One-cycle pulse when a new position is presented |

## Verification
The bench builds the block with its defaults: a 6-bit integer position, a 16-bit fraction, slow shifts of 6 and 10, and a fast reduction of 4. A 64-entry position space wraps within a few hundred output events, so every run crosses the wrap many times. The bench sweeps several input/output period pairs with ratios above and below one, a held-high strobe, coincident edges, and mid-run settling changes. It compares every cycle against an arithmetic position model. With these small shifts, a one-sample rate step settles within a few thousand cycles in both modes, which brings the fast-versus-slow error comparison within reach.

// File: rtl/servo_pkg.sv
package servo_pkg;
  typedef enum logic {
    SETTLE_FAST = 1'b0,
    SETTLE_SLOW = 1'b1
  } settle_e;
endpackage

// File: rtl/srv_edge_det.sv
module srv_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic evt_o
);
  logic s_q, s_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= 1'b0;
      s_qq <= 1'b0;
    end else begin
      s_q  <= strobe_i;
      s_qq <= s_q;
    end
  end

  assign evt_o = s_q & ~s_qq;
endmodule

// File: rtl/srv_phase_det.sv
module srv_phase_det #(
  parameter int INT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_evt_i,
  input  logic [INT_W-1:0]        rd_int_i,
  output logic signed [INT_W-1:0] err_o
);
  localparam logic [INT_W-1:0] HALF = INT_W'(1) << (INT_W - 1);

  logic [INT_W-1:0] wcnt_q, wcnt_d;
  logic [INT_W-1:0] diff;

  always_comb begin
    wcnt_d = wcnt_q + INT_W'(1);
    diff   = wcnt_q - rd_int_i - HALF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (in_evt_i) begin
      wcnt_q <= wcnt_d;
    end
  end

  assign err_o = signed'(diff);

  // R2: one input edge moves the write count by exactly one
  p_wcnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_evt_i |=> (wcnt_q == $past(wcnt_q) + INT_W'(1)));
  p_wcnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_evt_i |=> $stable(wcnt_q));
endmodule

// File: rtl/srv_loop_filter.sv
module srv_loop_filter
  import servo_pkg::*;
#(
  parameter int INT_W      = 6,
  parameter int FRAC_W     = 16,
  parameter int KP_SLOW    = 6,
  parameter int KI_SLOW    = 10,
  parameter int FAST_DELTA = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           upd_i,
  input  logic                           slow_sel_i,
  input  logic signed [INT_W-1:0]        err_i,
  output logic signed [INT_W+FRAC_W+1:0] incr_o
);
  localparam int ACC_W     = INT_W + FRAC_W + 2;
  localparam int KP_FAST   = KP_SLOW - FAST_DELTA;
  localparam int KI_FAST   = KI_SLOW - FAST_DELTA;
  localparam int SH_P_SLOW = FRAC_W - KP_SLOW;
  localparam int SH_I_SLOW = FRAC_W - KI_SLOW;
  localparam int SH_P_FAST = FRAC_W - KP_FAST;
  localparam int SH_I_FAST = FRAC_W - KI_FAST;
  localparam logic signed [ACC_W-1:0] UNITY = ACC_W'(1) <<< FRAC_W;

  settle_e                  mode_q;
  logic signed [ACC_W-1:0]  integ_q, integ_d;
  logic signed [ACC_W-1:0]  err_ext, prop, iterm;

  always_comb begin
    err_ext = {{(ACC_W-INT_W){err_i[INT_W-1]}}, err_i};
    if (mode_q == SETTLE_SLOW) begin
      prop  = err_ext <<< SH_P_SLOW;
      iterm = err_ext <<< SH_I_SLOW;
    end else begin
      prop  = err_ext <<< SH_P_FAST;
      iterm = err_ext <<< SH_I_FAST;
    end
    integ_d = upd_i ? (integ_q + iterm) : integ_q;
    incr_o  = integ_d + prop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SETTLE_SLOW;
      integ_q <= UNITY;
    end else begin
      mode_q <= settle_e'(slow_sel_i);
      if (upd_i) begin
        integ_q <= integ_d;
      end
    end
  end

  // R6: integrator moves only on output events
  p_integ_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(integ_q));
  // R7: fast mode applies the wider integral gain
  p_fast_gain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && err_i == INT_W'(1) && mode_q == SETTLE_FAST)
      |=> (integ_q == $past(integ_q) + (ACC_W'(1) <<< SH_I_FAST)));
endmodule

// File: rtl/srv_pos_accum.sv
module srv_pos_accum #(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           upd_i,
  input  logic signed [INT_W+FRAC_W+1:0] incr_i,
  output logic [INT_W-1:0]               pos_int_o,
  output logic [FRAC_W-1:0]              pos_frac_o,
  output logic                           valid_o
);
  localparam int POS_W = INT_W + FRAC_W;
  localparam logic [INT_W-1:0] START_INT = INT_W'((1 << INT_W) - (1 << (INT_W - 1)));

  logic [POS_W-1:0] pos_q, pos_d;
  logic             valid_q;

  always_comb begin
    pos_d = upd_i ? (pos_q + incr_i[POS_W-1:0]) : pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= {START_INT, {FRAC_W{1'b0}}};
      valid_q <= 1'b0;
    end else begin
      valid_q <= upd_i;
      if (upd_i) begin
        pos_q <= pos_d;
      end
    end
  end

  assign pos_int_o  = pos_q[POS_W-1:FRAC_W];
  assign pos_frac_o = pos_q[FRAC_W-1:0];
  assign valid_o    = valid_q;
endmodule

// File: rtl/asrc_ratio_servo.sv
module asrc_ratio_servo
  import servo_pkg::*;
#(
  parameter int INT_W      = 6,
  parameter int FRAC_W     = 16,
  parameter int KP_SLOW    = 6,
  parameter int KI_SLOW    = 10,
  parameter int FAST_DELTA = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_lr,
  input  logic              out_lr,
  input  logic              slow_sel,
  output logic [INT_W-1:0]  rd_start,
  output logic [FRAC_W-1:0] coef_ofs,
  output logic              out_valid
);
  localparam int ACC_W  = INT_W + FRAC_W + 2;
  localparam int N_STRB = 2;

  logic [1:0]               rst_pipe;
  logic                     rst_n_int;
  logic [N_STRB-1:0]        strobes, evts;
  logic                     in_evt, out_evt;
  logic signed [INT_W-1:0]  err;
  logic signed [ACC_W-1:0]  incr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe[1];

  assign strobes = {out_lr, in_lr};

  for (genvar g = 0; g < N_STRB; g++) begin : g_edge
    srv_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .strobe_i (strobes[g]),
      .evt_o    (evts[g])
    );
  end

  assign in_evt  = evts[0];
  assign out_evt = evts[1];

  srv_phase_det #(.INT_W(INT_W)) u_pd (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_evt_i (in_evt),
    .rd_int_i (rd_start),
    .err_o    (err)
  );

  srv_loop_filter #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .KP_SLOW(KP_SLOW),
    .KI_SLOW(KI_SLOW), .FAST_DELTA(FAST_DELTA)
  ) u_lf (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .upd_i      (out_evt),
    .slow_sel_i (slow_sel),
    .err_i      (err),
    .incr_o     (incr)
  );

  srv_pos_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_pa (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .upd_i      (out_evt),
    .incr_i     (incr),
    .pos_int_o  (rd_start),
    .pos_frac_o (coef_ofs),
    .valid_o    (out_valid)
  );

  // R3: one valid pulse per output event, one edge later
  p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    out_evt |=> out_valid);
  p_valid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !out_evt |=> !out_valid);
  // R4: position outputs hold between events
  p_pos_stable_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    !out_evt |=> ($stable(rd_start) && $stable(coef_ofs)));
endmodule

// File: tb/asrc_ratio_servo_tb.sv
module asrc_ratio_servo_tb;
  localparam int INT_W = 6, FRAC_W = 16, KP_SLOW = 6, KI_SLOW = 10, FAST_DELTA = 4;
  localparam int HALF = 1 << (INT_W - 1);
  localparam int ACC_W = INT_W + FRAC_W + 2;
  localparam longint POS_MASK = (64'sd1 << (INT_W + FRAC_W)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_lr = 1'b0, out_lr = 1'b0, slow_sel = 1'b1;
  logic [INT_W-1:0]  rd_start;
  logic [FRAC_W-1:0] coef_ofs;
  logic              out_valid;

  always #4 clk = ~clk;

  asrc_ratio_servo #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .KP_SLOW(KP_SLOW),
    .KI_SLOW(KI_SLOW), .FAST_DELTA(FAST_DELTA)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_lr(in_lr), .out_lr(out_lr),
    .slow_sel(slow_sel), .rd_start(rd_start), .coef_ofs(coef_ofs),
    .out_valid(out_valid)
  );

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 1'b0, eq_chk = 1'b0, have_prev = 1'b0, done = 1'b0;
  int prev_rd;

  // arithmetic model of the requirements
  bit     m_iq, m_iqq, m_oq, m_oqq, m_mode, m_valid;
  int     m_wcnt, m_maxerr;
  longint m_integ, m_pos;

  function automatic longint wrap_acc(longint v);
    longint r = v & ((64'sd1 << ACC_W) - 1);
    if (r >= (64'sd1 << (ACC_W - 1))) r = r - (64'sd1 << ACC_W);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_iq = 0; m_iqq = 0; m_oq = 0; m_oqq = 0; m_mode = 1; m_valid = 0;
      m_wcnt = 0; m_integ = 64'sd1 << FRAC_W;
      m_pos = longint'(HALF) << FRAC_W; m_maxerr = 0;
    end else begin
      bit ie, oe;
      ie = m_iq & ~m_iqq;
      oe = m_oq & ~m_oqq;
      m_valid = oe;
      if (oe) begin
        int e, kp, ki;
        e = (m_wcnt - int'(m_pos >> FRAC_W) - HALF) & ((1 << INT_W) - 1);
        if (e >= HALF) e = e - (1 << INT_W);          // R5 signed error
        if (e < 0 && -e > m_maxerr) m_maxerr = -e;
        if (e >= 0 && e > m_maxerr) m_maxerr = e;
        kp = m_mode ? KP_SLOW : KP_SLOW - FAST_DELTA; // R7 gains
        ki = m_mode ? KI_SLOW : KI_SLOW - FAST_DELTA;
        m_integ = wrap_acc(m_integ + (longint'(e) <<< (FRAC_W - ki)));
        m_pos = (m_pos + m_integ + (longint'(e) <<< (FRAC_W - kp))) & POS_MASK;
      end
      if (ie) m_wcnt = (m_wcnt + 1) & ((1 << INT_W) - 1);
      m_iqq = m_iq; m_iq = in_lr;
      m_oqq = m_oq; m_oq = out_lr;
      m_mode = slow_sel;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(out_valid == m_valid, "R3 out_valid timing", out_valid, m_valid);
      // R4/R6: outputs equal the model every cycle (held between events)
      chk(rd_start == int'(m_pos >> FRAC_W), "R6 rd_start", rd_start, m_pos >> FRAC_W);
      chk(coef_ofs == (m_pos & ((1 << FRAC_W) - 1)), "R6 coef_ofs", coef_ofs,
          m_pos & ((1 << FRAC_W) - 1));
      if (eq_chk && out_valid) begin
        if (have_prev) begin
          chk(((rd_start - prev_rd) & 63) == 1, "R8 equal-rate step", rd_start, (prev_rd + 1) & 63);
          chk(coef_ofs == 0, "R8 equal-rate fraction", coef_ofs, 0);
          if (prev_rd == 63) chk(rd_start == 0, "R10 wrap to zero", rd_start, 0);
        end
        prev_rd = rd_start; have_prev = 1'b1;
      end
    end
  end

  task automatic do_reset();
    cmp_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; in_lr = 1'b0; out_lr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic run(int pi, int po, int ncyc, int ph);
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      in_lr  = ((k + ph) % pi) < (pi / 2);
      out_lr = (k % po) < (po / 2);
    end
  endtask

  int slow_max, fast_max;

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(rd_start == HALF, "R1 reset rd_start", rd_start, HALF);
    chk(coef_ofs == 0, "R1 reset coef_ofs", coef_ofs, 0);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);

    // R8/R10: equal aligned rates, slow and fast
    eq_chk = 1'b1;
    run(8, 8, 1200, 0);
    slow_sel = 1'b0;
    run(8, 8, 1200, 0);
    eq_chk = 1'b0;

    // R2: input strobe held high for 50 cycles
    do_reset();
    run(100, 8, 800, 0);

    // R5/R6: sweep of ratios
    do_reset(); slow_sel = 1'b0; run(5, 8, 2000, 1);
    do_reset(); slow_sel = 1'b0; run(11, 8, 2000, 3);
    do_reset(); slow_sel = 1'b0; run(8, 13, 2000, 2);
    do_reset(); slow_sel = 1'b0; run(8, 3, 2000, 5);
    do_reset(); slow_sel = 1'b1; run(9, 8, 2000, 4);

    // R7: settling changed live
    do_reset();
    for (int s = 0; s < 6; s++) begin
      slow_sel = s[0];
      run(7, 8, 500, 0);
    end

    // R9: rate step, slow then fast
    do_reset(); slow_sel = 1'b1;
    run(8, 8, 800, 0);
    m_maxerr = 0;
    run(7, 8, 4000, 0);
    slow_max = m_maxerr;
    do_reset(); slow_sel = 1'b0;
    run(8, 8, 800, 0);
    m_maxerr = 0;
    run(7, 8, 4000, 0);
    fast_max = m_maxerr;
    chk(fast_max < slow_max, "R9 fast error below slow", fast_max, slow_max);
    chk(slow_max < HALF, "R9 slow stays separated", slow_max, HALF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule